// File: doc/BRIEF.md
# Memory Card Transfer Operation Controller

This block holds the operation control bits of a memory card host interface and runs the sequencer that follows one card command from start to finish. Software writes single bits through a small register port. One bit starts a command, one forcibly aborts the running command sequence, and one restarts a read that has been paused. The sequencer moves through the command-transmit, response and read-data phases. It drives a card clock enable that the card clock generator uses.

During read-data reception the sequencer stops the card clock in two cases: when the receive FIFO reports full, and at each block boundary of a multiblock read. It then waits for a resume request. The command serialiser, the CRC logic and the FIFO storage are not part of this block. Their progress reaches it as single-cycle handshake inputs.

The abort and resume bits are taken only inside their own phase windows. Each bit stays set until the protocol event that consumes it, and hardware then clears it.

Top module: `mcc_opctl`

## Requirements
- R1: After reset, and after a reset applied mid-sequence, `phase` is 0 (idle), `card_clk_en` is 0 and both register bytes read 0.
- R2: A write with `wr_sel`=1 and bit 0 set, made while idle, sets the start bit. The next cycle shows `phase`=1 (command transmit) with `card_clk_en`=1. The start bit reads 1 until the cycle after `cmd_tx_done`, when `phase` becomes 2 (response) and the bit reads 0. Writing 0 has no effect, and start writes outside idle are ignored.
- R3: A write with `wr_sel`=0 and bit 7 set (abort) is taken only in phases 2, 3 (read running) and 4 (read halted). It is ignored in idle and during command transmit.
- R4: An accepted abort reads back as bit 7 = 1 for exactly one cycle. On the following edge the sequencer returns to idle, drops `card_clk_en` and clears a pending resume bit.
- R5: In phase 2, `rsp_done` moves to phase 3 when `rsp_has_data`=1 and to idle otherwise.
- R6: In phase 3, `fifo_full` moves to phase 4 on the next edge, with `card_clk_en`=0.
- R7: In phase 3, `blk_end` with `multi_blk`=1 and `last_blk`=0 halts the read (phase 4). `blk_end` with `multi_blk`=0 does not halt. `blk_end` with `last_blk`=1 ends the sequence (idle), and this wins over a simultaneous `fifo_full`.
- R8: A write with `wr_sel`=0 and bit 6 set (resume) is taken only while the read is halted, or in the cycle the halt occurs. Otherwise it is ignored and bit 6 stays 0.
- R9: An accepted resume bit reads 1 until the read restarts. One cycle after it is set in phase 4, `phase` returns to 3 with `card_clk_en`=1 and the bit clears.
- R10: When a halt and a resume write occur in the same cycle, the card clock stays off for one cycle and then restarts.
- R11: Readback is registered and shows the bits one cycle after `rd_sel` is applied. With `rd_sel`=0 the data shows abort in bit 7 and resume in bit 6. With `rd_sel`=1 it shows start in bit 0. Every other bit reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write byte select: 0 control byte, 1 start byte |
| wr_data | input | DW | Write data |
| rd_sel | input | 1 | Read byte select: 0 control byte, 1 start byte |
| rd_data | output | DW | Registered readback |
| cmd_tx_done | input | 1 | Serialiser finished sending the command |
| rsp_done | input | 1 | Response phase finished |
| rsp_has_data | input | 1 | Command carries a read-data phase |
| fifo_full | input | 1 | Receive FIFO full |
| blk_end | input | 1 | A read block finished |
| last_blk | input | 1 | The finishing block is the last one |
| multi_blk | input | 1 | Multiblock read in progress |
| card_clk_en | output | 1 | Card clock enable (registered) |
| phase | output | 3 | Sequencer phase: 0 idle, 1 command, 2 response, 3 read running, 4 read halted |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, abort at bit 7, resume at bit 6 and start at bit 0. With these values every live and reserved bit of both bytes can be written and read back. A vector table walks four complete command sequences. Together they cover abort inside and outside its window, a halt on FIFO full, a halt at a block boundary, a halt and resume in the same cycle, and the last block winning over a full FIFO. Directed tests then apply reset at power-up and in the middle of a command.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CMD  = 3'd1,
    PH_RESP = 3'd2,
    PH_RUN  = 3'd3,
    PH_HALT = 3'd4
  } phase_t;
endpackage

// File: rtl/mcc_seq.sv
module mcc_seq
  import mcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_q,
  input  logic   abort_q,
  input  logic   cont_q,
  input  logic   cmd_tx_done,
  input  logic   rsp_done,
  input  logic   rsp_has_data,
  input  logic   fifo_full,
  input  logic   blk_end,
  input  logic   last_blk,
  input  logic   multi_blk,
  output phase_t phase_q,
  output logic   clk_en_q,
  output logic   halt_evt,
  output logic   resume_evt,
  output logic   tx_evt
);
  phase_t phase_d;
  logic   seq_end;

  // Event decode from the current phase.
  always_comb begin
    seq_end    = (phase_q == PH_RUN) && blk_end && last_blk;
    halt_evt   = (phase_q == PH_RUN) && !abort_q && !seq_end &&
                 (fifo_full || (blk_end && multi_blk));
    resume_evt = (phase_q == PH_HALT) && !abort_q && cont_q;
    tx_evt     = (phase_q == PH_CMD) && cmd_tx_done;
  end

  // Next-phase selection; a pending abort wins over everything.
  always_comb begin
    phase_d = phase_q;
    if (abort_q) begin
      phase_d = PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_q)     phase_d = PH_CMD;
        PH_CMD:  if (cmd_tx_done) phase_d = PH_RESP;
        PH_RESP: if (rsp_done)    phase_d = rsp_has_data ? PH_RUN : PH_IDLE;
        PH_RUN: begin
          if (seq_end)       phase_d = PH_IDLE;
          else if (halt_evt) phase_d = PH_HALT;
        end
        PH_HALT: if (cont_q) phase_d = PH_RUN;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      clk_en_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      clk_en_q <= (phase_d == PH_CMD) || (phase_d == PH_RESP) || (phase_d == PH_RUN);
    end
  end

  assert_idle_after_abort_R4: assert property (@(posedge clk) disable iff (rst)
    abort_q |=> (phase_q == PH_IDLE) && !clk_en_q);
  assert_clk_off_halt_R6: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HALT) |-> !clk_en_q);
  assert_halt_entry_R6: assert property (@(posedge clk) disable iff (rst)
    halt_evt |=> (phase_q == PH_HALT));
  assert_resume_restart_R9: assert property (@(posedge clk) disable iff (rst)
    resume_evt |=> (phase_q == PH_RUN) && clk_en_q);
  assert_cmd_clk_on_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) && start_q && !abort_q |=> (phase_q == PH_CMD) && clk_en_q);
endmodule

// File: rtl/mcc_regs.sv
module mcc_regs
  import mcc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int ABORT_POS = 7,
  parameter int CONT_POS  = 6,
  parameter int START_POS = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  input  phase_t        phase,
  input  logic          halt_evt,
  input  logic          resume_evt,
  input  logic          tx_evt,
  output logic          start_q,
  output logic          abort_q,
  output logic          cont_q,
  output logic [DW-1:0] rd_data
);
  localparam logic [DW-1:0] LIVE_MASK =
    (DW'(1) << ABORT_POS) | (DW'(1) << CONT_POS) | (DW'(1) << START_POS);

  logic          start_acc, abort_acc, cont_acc, abort_win;
  logic [DW-1:0] ctl_view, stt_view;

  always_comb begin
    abort_win = (phase == PH_RESP) || (phase == PH_RUN) || (phase == PH_HALT);
    start_acc = wr_en && wr_sel && wr_data[START_POS] && (phase == PH_IDLE) && !start_q;
    abort_acc = wr_en && !wr_sel && wr_data[ABORT_POS] && abort_win && !abort_q;
    cont_acc  = wr_en && !wr_sel && wr_data[CONT_POS] &&
                ((phase == PH_HALT) || halt_evt) && !abort_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      abort_q <= 1'b0;
      cont_q  <= 1'b0;
    end else begin
      if (abort_q || tx_evt) start_q <= 1'b0;
      else if (start_acc)    start_q <= 1'b1;

      if (abort_q)        abort_q <= 1'b0;
      else if (abort_acc) abort_q <= 1'b1;

      if (abort_q || resume_evt) cont_q <= 1'b0;
      else if (cont_acc)         cont_q <= 1'b1;
    end
  end

  // Readback byte assembly: reserved positions tie to zero.
  for (genvar i = 0; i < DW; i++) begin : g_view
    if (i == ABORT_POS) begin : g_abort
      assign ctl_view[i] = abort_q;
    end else if (i == CONT_POS) begin : g_cont
      assign ctl_view[i] = cont_q;
    end else begin : g_rsvd
      assign ctl_view[i] = 1'b0;
    end
    if (i == START_POS) begin : g_start
      assign stt_view[i] = start_q;
    end else begin : g_srsvd
      assign stt_view[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel ? stt_view : ctl_view;
  end

  assert_abort_window_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_q) |-> $past((phase == PH_RESP) || (phase == PH_RUN) || (phase == PH_HALT)));
  assert_abort_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    abort_q |=> !abort_q && !cont_q);
  assert_cont_window_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cont_q) |-> $past((phase == PH_HALT) || halt_evt));
  assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(start_q) |-> $past(phase == PH_IDLE));
  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~LIVE_MASK) == '0);
endmodule

// File: rtl/mcc_opctl.sv
module mcc_opctl
  import mcc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int ABORT_POS = 7,
  parameter int CONT_POS  = 6,
  parameter int START_POS = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          cmd_tx_done,
  input  logic          rsp_done,
  input  logic          rsp_has_data,
  input  logic          fifo_full,
  input  logic          blk_end,
  input  logic          last_blk,
  input  logic          multi_blk,
  output logic          card_clk_en,
  output logic [2:0]    phase
);
  phase_t ph;
  logic   start_q, abort_q, cont_q;
  logic   halt_evt, resume_evt, tx_evt;

  mcc_regs #(
    .DW(DW), .ABORT_POS(ABORT_POS), .CONT_POS(CONT_POS), .START_POS(START_POS)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .phase(ph), .halt_evt(halt_evt), .resume_evt(resume_evt), .tx_evt(tx_evt),
    .start_q(start_q), .abort_q(abort_q), .cont_q(cont_q), .rd_data(rd_data)
  );

  mcc_seq u_seq (
    .clk(clk), .rst(rst),
    .start_q(start_q), .abort_q(abort_q), .cont_q(cont_q),
    .cmd_tx_done(cmd_tx_done), .rsp_done(rsp_done), .rsp_has_data(rsp_has_data),
    .fifo_full(fifo_full), .blk_end(blk_end), .last_blk(last_blk), .multi_blk(multi_blk),
    .phase_q(ph), .clk_en_q(card_clk_en),
    .halt_evt(halt_evt), .resume_evt(resume_evt), .tx_evt(tx_evt)
  );

  assign phase = ph;
endmodule

// File: tb/sim_mcc_opctl.sv
module sim_mcc_opctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = '0;
  logic       cmd_tx_done = 0, rsp_done = 0, rsp_has_data = 0;
  logic       fifo_full = 0, blk_end = 0, last_blk = 0, multi_blk = 0;
  logic [7:0] rd_data;
  logic       card_clk_en;
  logic [2:0] phase;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  mcc_opctl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .cmd_tx_done(cmd_tx_done),
    .rsp_done(rsp_done), .rsp_has_data(rsp_has_data), .fifo_full(fifo_full),
    .blk_end(blk_end), .last_blk(last_blk), .multi_blk(multi_blk),
    .card_clk_en(card_clk_en), .phase(phase)
  );

  // Row layout: wr_en, wr_sel, wr_data, rd_sel,
  // {cmd_tx_done, rsp_done, rsp_has_data, fifo_full, blk_end, last_blk, multi_blk},
  // expected phase, expected card_clk_en, expected rd_data after the edge.
  localparam int NV = 40;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1,1'b1,8'h01,1'b1, 7'b0000000, 3'd0,1'b0,8'h00}, // 0  R2 start write
    {1'b0,1'b0,8'h00,1'b1, 7'b0000000, 3'd1,1'b1,8'h01}, // 1  R2 command phase
    {1'b1,1'b0,8'h80,1'b0, 7'b0000000, 3'd1,1'b1,8'h00}, // 2  R3 abort in command phase
    {1'b0,1'b0,8'h00,1'b0, 7'b0000000, 3'd1,1'b1,8'h00}, // 3  R3 ignored
    {1'b0,1'b0,8'h00,1'b1, 7'b1000000, 3'd2,1'b1,8'h01}, // 4  R2 tx done
    {1'b0,1'b0,8'h00,1'b1, 7'b0000000, 3'd2,1'b1,8'h00}, // 5  R2 start cleared
    {1'b0,1'b0,8'h00,1'b0, 7'b0110000, 3'd3,1'b1,8'h00}, // 6  R5 to read
    {1'b1,1'b0,8'h40,1'b0, 7'b0000000, 3'd3,1'b1,8'h00}, // 7  R8 resume while running
    {1'b0,1'b0,8'h00,1'b0, 7'b0001000, 3'd4,1'b0,8'h00}, // 8  R6 fifo full halts
    {1'b0,1'b0,8'h00,1'b0, 7'b0000000, 3'd4,1'b0,8'h00}, // 9  R6 stays halted
    {1'b1,1'b0,8'h40,1'b0, 7'b0000000, 3'd4,1'b0,8'h00}, // 10 R8 resume accepted
    {1'b0,1'b0,8'h00,1'b0, 7'b0000000, 3'd3,1'b1,8'h40}, // 11 R9 restart
    {1'b0,1'b0,8'h00,1'b0, 7'b0000000, 3'd3,1'b1,8'h00}, // 12 R9 bit cleared
    {1'b1,1'b0,8'h40,1'b0, 7'b0000101, 3'd4,1'b0,8'h00}, // 13 R10 halt+resume
    {1'b0,1'b0,8'h00,1'b0, 7'b0000000, 3'd3,1'b1,8'h40}, // 14 R10 restart after one
    {1'b0,1'b0,8'h00,1'b0, 7'b0001000, 3'd4,1'b0,8'h00}, // 15 R6 halt again
    {1'b1,1'b0,8'hC0,1'b0, 7'b0000000, 3'd4,1'b0,8'h00}, // 16 R4 abort+resume
    {1'b0,1'b0,8'h00,1'b0, 7'b0000000, 3'd0,1'b0,8'hC0}, // 17 R4 to idle
    {1'b0,1'b0,8'h00,1'b0, 7'b0000000, 3'd0,1'b0,8'h00}, // 18 R4 bits cleared
    {1'b1,1'b0,8'h80,1'b0, 7'b0000000, 3'd0,1'b0,8'h00}, // 19 R3 abort in idle
    {1'b0,1'b0,8'h00,1'b0, 7'b0000000, 3'd0,1'b0,8'h00}, // 20 R3 ignored
    {1'b1,1'b1,8'hFF,1'b1, 7'b0000000, 3'd0,1'b0,8'h00}, // 21 R11 start byte all ones
    {1'b0,1'b0,8'h00,1'b1, 7'b0000000, 3'd1,1'b1,8'h01}, // 22 R11 only bit 0
    {1'b1,1'b1,8'h01,1'b1, 7'b1000000, 3'd2,1'b1,8'h01}, // 23 R2 start outside idle
    {1'b0,1'b0,8'h00,1'b1, 7'b0100000, 3'd0,1'b0,8'h00}, // 24 R5 no data -> idle
    {1'b1,1'b1,8'h01,1'b0, 7'b0000000, 3'd0,1'b0,8'h00}, // 25 R2
    {1'b0,1'b0,8'h00,1'b0, 7'b0000000, 3'd1,1'b1,8'h00}, // 26 R2
    {1'b0,1'b0,8'h00,1'b0, 7'b1000000, 3'd2,1'b1,8'h00}, // 27 R2
    {1'b0,1'b0,8'h00,1'b0, 7'b0110000, 3'd3,1'b1,8'h00}, // 28 R5
    {1'b0,1'b0,8'h00,1'b0, 7'b0000100, 3'd3,1'b1,8'h00}, // 29 R7 single block end
    {1'b0,1'b0,8'h00,1'b0, 7'b0001110, 3'd0,1'b0,8'h00}, // 30 R7 last block wins
    {1'b1,1'b1,8'h01,1'b0, 7'b0000000, 3'd0,1'b0,8'h00}, // 31 R2
    {1'b0,1'b0,8'h00,1'b0, 7'b0000000, 3'd1,1'b1,8'h00}, // 32 R2
    {1'b0,1'b0,8'h00,1'b0, 7'b1000000, 3'd2,1'b1,8'h00}, // 33 R2
    {1'b1,1'b0,8'h80,1'b0, 7'b0000000, 3'd2,1'b1,8'h00}, // 34 R4 abort in response
    {1'b0,1'b0,8'h00,1'b0, 7'b0000000, 3'd0,1'b0,8'h80}, // 35 R4 idle
    {1'b1,1'b0,8'h3F,1'b0, 7'b0000000, 3'd0,1'b0,8'h00}, // 36 R11 reserved write
    {1'b0,1'b0,8'h00,1'b0, 7'b0000000, 3'd0,1'b0,8'h00}, // 37 R11 reads zero
    {1'b1,1'b1,8'h00,1'b1, 7'b0000000, 3'd0,1'b0,8'h00}, // 38 R2 zero write
    {1'b0,1'b0,8'h00,1'b1, 7'b0000000, 3'd0,1'b0,8'h00}  // 39 R2 no effect
  };

  function automatic string tag_of(int i);
    case (i)
      2, 3, 19, 20:           return "R3";
      16, 17, 18, 34, 35:     return "R4";
      6, 24, 28:              return "R5";
      8, 9, 15:               return "R6";
      29, 30:                 return "R7";
      7, 10:                  return "R8";
      11, 12:                 return "R9";
      13, 14:                 return "R10";
      21, 22, 36, 37:         return "R11";
      default:                return "R2";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string req, int ph, int ce, int rd);
    check(req, "phase", int'(phase), ph);
    check(req, "card_clk_en", int'(card_clk_en), ce);
    check(req, "rd_data", int'(rd_data), rd);
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_sel = 0; wr_data = '0; rd_sel = 0;
    {cmd_tx_done, rsp_done, rsp_has_data, fifo_full, blk_end, last_blk, multi_blk} = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_outs("R1", 0, 0, 0); // reset state
    rd_sel = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", "start byte after reset", int'(rd_data), 0);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      wr_en   = v[29];
      wr_sel  = v[28];
      wr_data = v[27:20];
      rd_sel  = v[19];
      {cmd_tx_done, rsp_done, rsp_has_data, fifo_full, blk_end, last_blk, multi_blk} = v[18:12];
      @(posedge clk); @(negedge clk);
      check_outs(tag_of(i), int'(v[11:9]), int'(v[8]), int'(v[7:0]));
    end

    // Directed: reset in the middle of a command (R1).
    idle_inputs();
    wr_en = 1; wr_sel = 1; wr_data = 8'h01;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    @(posedge clk); @(negedge clk);
    check("R2", "directed command phase", int'(phase), 1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check_outs("R1", 0, 0, 0);
    rd_sel = 1;
    @(posedge clk); @(negedge clk);
    check("R1", "start bit cleared by reset", int'(rd_data), 0);
    check("R1", "phase stays idle", int'(phase), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule